// File: doc/BRIEF.md
# Registered Programmable AND-Array Logic Device

This block is a small sum-of-products logic device. An AND plane, set by a configuration vector, forms product terms from every dedicated input and every pin feedback signal, each in true or complemented form. Each output cell has a fixed, private group of product terms that are ORed together. Behind the OR gate sits a per-cell output stage that the user sets with two bits. The stage can release the pin so it acts as an extra input, drive the pin straight from the OR gate, or drive it from a flip-flop loaded on the rising clock edge.

The value seen on each pin is routed back into the AND plane. This lets one cell's result feed another cell's terms, so multi-level functions can be built. With registered cells it also allows small state machines. Combinational feedback is resolved by a fixed number of unrolled evaluation stages rather than by a physical loop, so acyclic chains up to the number of output cells settle within one cycle.

Configuration is presented on static ports. A system either ties them to constants or loads them once and holds them.

Top module: `pal_device`

## Requirements
- R1: Signal index s runs over dedicated inputs 0..7 and then pin feedbacks 8..11. Term t of cell m reads configuration bits `andCfg[(m*4+t)*24 +: 24]`, where bit s selects the true form of signal s and bit 12+s selects its complement. A product term is the AND of its selected literals.
- R2: A product term with no configuration bit set evaluates to 0.
- R3: A cell's OR result is the OR of its own four terms only. Terms of other cells never reach it.
- R4: With `mcEnable[m]`=0, `pinOe[m]` is 0 and `pinOut[m]` is 0, and the AND plane takes feedback signal 8+m from `pinIn[m]`.
- R5: With `mcEnable[m]`=1 and `mcSelect[m]`=0, `pinOut[m]` equals the cell's OR result in the same cycle, with no clock edge between.
- R6: With `mcEnable[m]`=1 and `mcSelect[m]`=1, `pinOut[m]` shows a flip-flop that loads the OR result at each rising edge of `clk` and holds it between edges.
- R7: For an enabled pin, feedback signal 8+m is the cell's own output, and `pinIn[m]` has no effect.
- R8: Acyclic combinational feedback chains up to four cells deep give the correct final value within the same cycle.
- R9: A synchronous active-high `rst` sampled at a rising edge clears every cell flip-flop to 0, and this takes priority over the OR result being loaded at that edge.
- R10: Registered feedback holds state across edges. A cell programmed as `q ^ in` toggles on every edge while `in`=1 and holds while `in`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell flip-flops |
| rst | input | 1 | Synchronous active-high clear of the flip-flops |
| dedIn | input | 8 | Dedicated logic inputs |
| pinIn | input | 4 | External value present on each pin when it is not driven |
| andCfg | input | 384 | AND-plane connection bits, layout per R1 |
| mcEnable | input | 4 | Per-cell pin driver enable |
| mcSelect | input | 4 | Per-cell output source: 0 OR gate, 1 flip-flop |
| pinOut | output | 4 | Value driven onto each pin (0 when not driven) |
| pinOe | output | 4 | Per-pin output enable |

## Verification
A reset and a capture can land on the same rising edge. The flip-flop then has both a clear request and an OR result of 1 to load. The bench provokes this by programming a registered cell whose term is satisfied and holding `rst` high across an edge. Just after that edge it expects the pin to read 0. After `rst` falls it expects the next edge to load 1. A second overlap occurs when a pin's external input changes while the pin is driven. Here the AND plane must keep using the cell output, and the bench judges this by driving `pinIn` opposite to the expected feedback during the truth-table walk.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Strobes handed from the cell control to the datapath
  typedef struct packed {
    logic drive;    // pin driver on
    logic fromReg;  // pin sourced by the flip-flop
  } mcCtrl_t;

endpackage

// File: rtl/pal_and_or.sv
module pal_and_or #(
  parameter int NUM_IN = 8,
  parameter int NUM_MC = 4,
  parameter int NUM_PT = 4
) (
  input  logic [NUM_IN-1:0]                        dedIn,
  input  logic [NUM_MC-1:0]                        fbIn,
  input  logic [NUM_MC*NUM_PT*2*(NUM_IN+NUM_MC)-1:0] andCfg,
  output logic [NUM_MC-1:0]                        orOut
);
  localparam int NUM_SIG = NUM_IN + NUM_MC;
  localparam int NUM_LIT = 2 * NUM_SIG;

  logic [NUM_SIG-1:0] sigVec;
  logic [NUM_LIT-1:0] litVec;

  assign sigVec = {fbIn, dedIn};
  assign litVec = {~sigVec, sigVec};  // complements sit above true forms

  for (genvar m = 0; m < NUM_MC; m++) begin : g_cell
    logic [NUM_PT-1:0] termHit;
    for (genvar t = 0; t < NUM_PT; t++) begin : g_term
      logic [NUM_LIT-1:0] conn;
      assign conn = andCfg[(m*NUM_PT+t)*NUM_LIT +: NUM_LIT];
      // an empty term yields 0, otherwise every selected literal must be 1
      assign termHit[t] = (|conn) & (&(litVec | ~conn));
    end
    assign orOut[m] = |termHit;
  end
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int NUM_MC = 4
) (
  input  logic [NUM_MC-1:0]  mcEnable,
  input  logic [NUM_MC-1:0]  mcSelect,
  output mcCtrl_t [NUM_MC-1:0] ctrl
);
  for (genvar m = 0; m < NUM_MC; m++) begin : g_dec
    always_comb begin
      ctrl[m].drive   = mcEnable[m];
      ctrl[m].fromReg = mcEnable[m] & mcSelect[m];
    end
  end
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_MC = 4,
  parameter int NUM_PT = 4
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [NUM_IN-1:0]                          dedIn,
  input  logic [NUM_MC-1:0]                          pinIn,
  input  logic [NUM_MC*NUM_PT*2*(NUM_IN+NUM_MC)-1:0] andCfg,
  input  mcCtrl_t [NUM_MC-1:0]                       ctrl,
  output logic [NUM_MC-1:0]                          pinOut,
  output logic [NUM_MC-1:0]                          pinOe,
  output logic [NUM_MC-1:0]                          orFinal
);
  logic [NUM_MC-1:0] regQ;

  // Unrolled settling: stage k sees the previous stage's OR results as
  // combinational feedback, so a chain of depth NUM_MC resolves.
  for (genvar k = 0; k < NUM_MC; k++) begin : g_stage
    logic [NUM_MC-1:0] fbK;
    logic [NUM_MC-1:0] orK;
    for (genvar m = 0; m < NUM_MC; m++) begin : g_fb
      if (k == 0) begin : g_first
        assign fbK[m] = !ctrl[m].drive ? pinIn[m] :
                        (ctrl[m].fromReg ? regQ[m] : 1'b0);
      end else begin : g_next
        assign fbK[m] = !ctrl[m].drive ? pinIn[m] :
                        (ctrl[m].fromReg ? regQ[m] : g_stage[k-1].orK[m]);
      end
    end
    pal_and_or #(
      .NUM_IN(NUM_IN), .NUM_MC(NUM_MC), .NUM_PT(NUM_PT)
    ) u_plane (
      .dedIn (dedIn),
      .fbIn  (fbK),
      .andCfg(andCfg),
      .orOut (orK)
    );
  end

  assign orFinal = g_stage[NUM_MC-1].orK;

  always_ff @(posedge clk) begin
    if (rst) regQ <= '0;
    else     regQ <= orFinal;
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_pin
    always_comb begin
      pinOe[m]  = ctrl[m].drive;
      pinOut[m] = ctrl[m].drive & (ctrl[m].fromReg ? regQ[m] : orFinal[m]);
    end
  end
endmodule

// File: rtl/pal_device.sv
module pal_device
  import pal_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_MC = 4,
  parameter int NUM_PT = 4,
  localparam int CFG_W = NUM_MC * NUM_PT * 2 * (NUM_IN + NUM_MC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] dedIn,
  input  logic [NUM_MC-1:0] pinIn,
  input  logic [CFG_W-1:0]  andCfg,
  input  logic [NUM_MC-1:0] mcEnable,
  input  logic [NUM_MC-1:0] mcSelect,
  output logic [NUM_MC-1:0] pinOut,
  output logic [NUM_MC-1:0] pinOe
);
  mcCtrl_t [NUM_MC-1:0] ctrl;
  logic [NUM_MC-1:0]    orFinal;

  pal_ctrl #(.NUM_MC(NUM_MC)) u_ctrl (
    .mcEnable(mcEnable),
    .mcSelect(mcSelect),
    .ctrl    (ctrl)
  );

  pal_datapath #(
    .NUM_IN(NUM_IN), .NUM_MC(NUM_MC), .NUM_PT(NUM_PT)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .dedIn  (dedIn),
    .pinIn  (pinIn),
    .andCfg (andCfg),
    .ctrl   (ctrl),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .orFinal(orFinal)
  );
endmodule

// File: rtl/pal_device_chk.sv
module pal_device_chk #(
  parameter int NUM_MC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_MC-1:0] mcEnable,
  input logic [NUM_MC-1:0] mcSelect,
  input logic [NUM_MC-1:0] pinOut,
  input logic [NUM_MC-1:0] pinOe,
  input logic [NUM_MC-1:0] orFinal
);
  for (genvar m = 0; m < NUM_MC; m++) begin : g_chk
    AST_OE_TRACKS_ENABLE: assert property (@(posedge clk) disable iff (rst) pinOe[m] == mcEnable[m]); // R4
    AST_UNDRIVEN_QUIET: assert property (@(posedge clk) disable iff (rst) !pinOe[m] |-> !pinOut[m]); // R4
    AST_COMB_PASSTHRU: assert property (@(posedge clk) disable iff (rst) (mcEnable[m] && !mcSelect[m]) |-> pinOut[m] == orFinal[m]); // R5
    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst) (mcEnable[m] && mcSelect[m]) |=> (!(mcEnable[m] && mcSelect[m]) || pinOut[m] == $past(orFinal[m]))); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!(mcEnable[m] && mcSelect[m]) || !pinOut[m])); // R9
  end
endmodule

bind pal_device pal_device_chk #(.NUM_MC(NUM_MC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mcEnable(mcEnable),
  .mcSelect(mcSelect),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .orFinal (orFinal)
);

// File: tb/pal_device_tb.sv
module pal_device_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN  = 8;
  localparam int NUM_MC  = 4;
  localparam int NUM_PT  = 4;
  localparam int NUM_SIG = NUM_IN + NUM_MC;
  localparam int NUM_LIT = 2 * NUM_SIG;
  localparam int CFG_W   = NUM_MC * NUM_PT * NUM_LIT;

  // {a, b, c, g, f}: g = b xnor c, f = a xor g
  localparam logic [4:0] VEC [8] = '{
    5'b00011, 5'b00100, 5'b01000, 5'b01111,
    5'b10010, 5'b10101, 5'b11001, 5'b11110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_IN-1:0] dedIn = '0;
  logic [NUM_MC-1:0] pinIn = '0;
  logic [CFG_W-1:0]  andCfg = '0;
  logic [NUM_MC-1:0] mcEnable = '0;
  logic [NUM_MC-1:0] mcSelect = '0;
  logic [NUM_MC-1:0] pinOut;
  logic [NUM_MC-1:0] pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_device dut_i (
    .clk(clk), .rst(rst), .dedIn(dedIn), .pinIn(pinIn), .andCfg(andCfg),
    .mcEnable(mcEnable), .mcSelect(mcSelect), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic int litT(input int s); return s; endfunction
  function automatic int litC(input int s); return NUM_SIG + s; endfunction

  task automatic setLit(input int m, input int t, input int lit);
    andCfg[(m*NUM_PT+t)*NUM_LIT + lit] = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    // ---- reset coinciding with a satisfied registered term (R9) ----
    setLit(0, 0, litT(0));
    mcEnable = 4'b0001; mcSelect = 4'b0001; dedIn[0] = 1'b1;
    tick();
    chk("R9 clear wins over capture", pinOut[0], 1'b0);
    chk("R4 oe follows enable", pinOe[0], 1'b1);
    rst = 1'b0;
    tick();
    chk("R6 capture after reset", pinOut[0], 1'b1);
    dedIn[0] = 1'b0; #1;
    chk("R6 holds between edges", pinOut[0], 1'b1);
    tick();
    chk("R6 next edge loads 0", pinOut[0], 1'b0);

    // ---- two-level feedback, combinational (R1 R3 R5 R7 R8) ----
    andCfg = '0;
    setLit(1, 0, litT(1)); setLit(1, 0, litT(2));
    setLit(1, 1, litC(1)); setLit(1, 1, litC(2));
    setLit(0, 0, litC(0)); setLit(0, 0, litT(NUM_IN+1));
    setLit(0, 1, litT(0)); setLit(0, 1, litC(NUM_IN+1));
    mcEnable = 4'b0011; mcSelect = 4'b0000;
    for (int i = 0; i < 8; i++) begin
      dedIn = '0;
      dedIn[0] = VEC[i][4]; dedIn[1] = VEC[i][3]; dedIn[2] = VEC[i][2];
      pinIn = 4'b1111; pinIn[1] = ~VEC[i][1];  // R7: opposite of the fed-back value
      #1;
      chk("R1 R5 inner g", pinOut[1], VEC[i][1]);
      chk("R8 R7 outer f", pinOut[0], VEC[i][0]);
    end

    // ---- same function with registered outer cell (R6) ----
    mcSelect = 4'b0001;
    for (int i = 0; i < 8; i++) begin
      dedIn = '0;
      dedIn[0] = VEC[i][4]; dedIn[1] = VEC[i][3]; dedIn[2] = VEC[i][2];
      tick();
      chk("R6 registered f", pinOut[0], VEC[i][0]);
    end

    // ---- empty terms and private groups (R2 R3) ----
    mcEnable = 4'b1011; mcSelect = 4'b0000;
    dedIn = 8'hFF; #1;
    chk("R2 empty cell with all ones", pinOut[3], 1'b0);
    dedIn = 8'h00; #1;
    chk("R2 empty cell with all zeros", pinOut[3], 1'b0);
    andCfg = '0;
    setLit(0, 0, litT(4)); setLit(0, 3, litT(5));
    mcEnable = 4'b0011;
    for (int i = 0; i < 4; i++) begin
      dedIn = '0; dedIn[4] = i[0]; dedIn[5] = i[1]; #1;
      chk("R3 or of own terms", pinOut[0], i[0] | i[1]);
    end
    chk("R3 neighbour unaffected", pinOut[1], 1'b0);

    // ---- disabled pin acts as an input (R4) ----
    andCfg = '0;
    setLit(0, 0, litT(NUM_IN+2));
    mcEnable = 4'b0001;
    pinIn = 4'b0100; #1;
    chk("R4 oe low", pinOe[2], 1'b0);
    chk("R4 undriven out", pinOut[2], 1'b0);
    chk("R4 pin feeds plane high", pinOut[0], 1'b1);
    pinIn = 4'b0000; #1;
    chk("R4 pin feeds plane low", pinOut[0], 1'b0);

    // ---- four-deep combinational chain (R8) ----
    andCfg = '0;
    setLit(3, 0, litT(0));
    setLit(2, 0, litT(NUM_IN+3));
    setLit(1, 0, litT(NUM_IN+2));
    setLit(0, 0, litT(NUM_IN+1));
    mcEnable = 4'b1111; mcSelect = 4'b0000;
    dedIn = 8'h01; #1;
    chk("R8 depth four high", pinOut[0], 1'b1);
    dedIn = 8'h00; #1;
    chk("R8 depth four low", pinOut[0], 1'b0);

    // ---- registered toggle cell (R10) ----
    andCfg = '0;
    setLit(2, 0, litC(NUM_IN+2)); setLit(2, 0, litT(3));
    setLit(2, 1, litT(NUM_IN+2)); setLit(2, 1, litC(3));
    mcEnable = 4'b0100; mcSelect = 4'b0100;
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R9 toggle cleared", pinOut[2], 1'b0);
    dedIn = 8'h08;
    tick(); chk("R10 toggle to 1", pinOut[2], 1'b1);
    tick(); chk("R10 toggle to 0", pinOut[2], 1'b0);
    tick(); chk("R10 toggle to 1 again", pinOut[2], 1'b1);
    dedIn = 8'h00;
    tick(); chk("R10 hold", pinOut[2], 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule